// File: doc/BRIEF.md
# Packet Interrupt Coalescer with Idle Timeout

This block sits next to one DMA channel and decides when that channel may interrupt the processor. Rather than raising an interrupt for every finished packet, it counts end-of-frame completions and raises a completion flag only when a programmed number of them has built up. If completions are waiting but the count stalls below that number, an idle-delay timer raises a second flag, so a trickle of traffic is not held back forever. A third flag records DMA error pulses.

Software reaches the block through a two-register bus. The control register holds the threshold, the delay value and one enable bit per cause. The status register holds the three flags in the same bit positions as their enables, and each flag is cleared by writing a one to it. The single interrupt line is high whenever a flag is set and its enable bit is also set. Clearing an enable therefore silences a cause without losing its flag. The delay counts in ticks of a prescaled clock. The prescale ratio is a parameter.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the control register reads 0xFE180000, which is delay 254 in bits 31:24, threshold 24 in bits 23:16 and all enables clear. The status register reads 0 and the interrupt line is low. Unassigned bits in either register read as 0.
- R2: When the number of completions since the count last restarted reaches the threshold, status bit 12 (completion) is set at that clock edge and the count restarts at zero.
- R3: A threshold of 0 behaves as a threshold of 1, so every completion sets bit 12.
- R4: A control write that changes the threshold field restarts the count at zero, and a completion in that same cycle is not counted. A control write that leaves the threshold unchanged keeps the count.
- R5: While the count is non-zero and no completion arrives, status bit 13 (delay) is set exactly D×PRESCALE cycles after the last completion, where D is the delay field (bits 31:24). At that edge the count returns to zero. Every completion restarts this wait.
- R6: A delay field of 0 disables the timer, so bit 13 is never set.
- R7: An error pulse sets status bit 14 on the next edge.
- R8: A status write clears every flag whose bit is 1 in the written data and leaves the other flags unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: The interrupt line equals the OR over bits 12 to 14 of (status AND control enable). Changing an enable never alters the status flags, so re-enabling a cause brings back its pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done_i | input | 1 | One-cycle pulse per end-of-frame completion |
| dma_err_i | input | 1 | One-cycle pulse per DMA error |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a prescale of 3 instead of 125. This keeps exact delay-expiry edges, restart-on-completion and flush-on-expiry within a few tens of cycles. The bench programs small thresholds (0 to 10) and delay values of 3 and 5. As a result, threshold wrap, the zero-threshold case and timer expiry racing against further completions all occur many times during the random phase, which also mixes in threshold rewrites and same-cycle set/clear of flags.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int REG_W   = 32;
   localparam int CMP_BIT = 12;
   localparam int DLY_BIT = 13;
   localparam int ERR_BIT = 14;
   localparam int THR_LSB = 16;
   localparam int DLY_LSB = 24;
   localparam int FLD_W   = 8;

   // order matches bit positions 14..12
   typedef struct packed {
      logic err;
      logic dly;
      logic cmp;
   } irq_vec_t;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int THR_W   = 8,
   parameter int DLY_W   = 8,
   parameter int DEF_THR = 24,
   parameter int DEF_DLY = 254
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             sel,
   input  logic [REG_W-1:0] wdata,
   input  irq_vec_t         set_v,
   output logic [REG_W-1:0] rdata,
   output logic [THR_W-1:0] thr,
   output logic [DLY_W-1:0] dly,
   output irq_vec_t         en_v,
   output irq_vec_t         flag_v,
   output logic             thr_chg
);

   localparam logic [THR_W-1:0] THR_RST = THR_W'(DEF_THR);
   localparam logic [DLY_W-1:0] DLY_RST = DLY_W'(DEF_DLY);

   logic     ctrl_we;
   logic     stat_we;
   irq_vec_t clr_v;

   assign ctrl_we = we && (sel == SEL_CTRL);
   assign stat_we = we && (sel == SEL_STAT);
   assign thr_chg = ctrl_we && (wdata[THR_LSB +: THR_W] != thr);
   assign clr_v   = stat_we ? irq_vec_t'(wdata[ERR_BIT:CMP_BIT]) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr  <= THR_RST;
         dly  <= DLY_RST;
         en_v <= '0;
      end else if (ctrl_we) begin
         thr  <= wdata[THR_LSB +: THR_W];
         dly  <= wdata[DLY_LSB +: DLY_W];
         en_v <= irq_vec_t'(wdata[ERR_BIT:CMP_BIT]);
      end
   end

   // write-one-to-clear; a set in the same cycle wins
   always_ff @(posedge clk) begin
      if (!rst_n) flag_v <= '0;
      else        flag_v <= (flag_v & ~clr_v) | set_v;
   end

   always_comb begin
      rdata = '0;
      if (sel == SEL_STAT) begin
         rdata[ERR_BIT:CMP_BIT] = flag_v;
      end else begin
         rdata[THR_LSB +: THR_W] = thr;
         rdata[DLY_LSB +: DLY_W] = dly;
         rdata[ERR_BIT:CMP_BIT]  = en_v;
      end
   end

   a_r8_w1c_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && wdata[CMP_BIT] && !set_v.cmp) |=> !flag_v.cmp);

   a_r8_zero_write_keeps : assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !wdata[ERR_BIT] && flag_v.err) |=> flag_v.err);

   a_r9_enable_write_keeps_flags : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && set_v == '0) |=> flag_v == $past(flag_v));

endmodule

// File: rtl/irqc_pkt_counter.sv
module irqc_pkt_counter #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             restart,
   input  logic             flush,
   input  logic [THR_W-1:0] thr,
   output logic             reach,
   output logic             pending
);

   logic [THR_W-1:0] cnt;
   logic [THR_W-1:0] thr_eff;
   logic [THR_W:0]   cnt_inc;

   assign thr_eff = (thr == '0) ? THR_W'(1) : thr;
   assign cnt_inc = {1'b0, cnt} + (THR_W+1)'(1);
   assign reach   = done && !restart && (cnt_inc >= {1'b0, thr_eff});
   assign pending = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (done)    cnt <= reach ? '0 : cnt_inc[THR_W-1:0];
      else if (flush)   cnt <= '0;
   end

   a_r2_count_below_threshold : assert property (@(posedge clk) disable iff (!rst_n)
      cnt < thr_eff);

   a_r4_restart_drops_count : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !pending);

endmodule

// File: rtl/irqc_delay_timer.sv
module irqc_delay_timer #(
   parameter int DLY_W    = 8,
   parameter int PRESCALE = 125
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pending,
   input  logic             kick,
   input  logic [DLY_W-1:0] dly,
   output logic             expire
);

   logic             hold;
   logic             tick;
   logic [DLY_W-1:0] ticks;

   assign hold = !pending || kick || (dly == '0);

   generate
      if (PRESCALE == 1) begin : g_no_prescale
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] pre;
         assign tick = (pre == PS_LAST);
         always_ff @(posedge clk) begin
            if (!rst_n)    pre <= '0;
            else if (hold) pre <= '0;
            else if (tick) pre <= '0;
            else           pre <= pre + PS_W'(1);
         end
      end
   endgenerate

   assign expire = !hold && tick && (ticks == dly - DLY_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)        ticks <= '0;
      else if (hold)     ticks <= '0;
      else if (expire)   ticks <= '0;
      else if (tick)     ticks <= ticks + DLY_W'(1);
   end

   a_r5_ticks_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      !hold |-> ticks < dly);

   a_r5_kick_restarts : assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> ticks == '0);

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
   import irqc_pkg::*;
#(
   parameter int THR_W    = 8,
   parameter int DLY_W    = 8,
   parameter int DEF_THR  = 24,
   parameter int DEF_DLY  = 254,
   parameter int PRESCALE = 125
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pkt_done_i,
   input  logic        dma_err_i,
   input  logic        reg_we_i,
   input  logic        reg_sel_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   output logic        irq_o
);

   generate
      if (THR_W < 1 || THR_W > FLD_W) begin : g_bad_thr_w
         $error("THR_W must lie in 1..8");
      end
      if (DLY_W < 1 || DLY_W > FLD_W) begin : g_bad_dly_w
         $error("DLY_W must lie in 1..8");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (DEF_THR < 0 || DEF_THR >= (1 << THR_W)) begin : g_bad_def_thr
         $error("DEF_THR does not fit THR_W");
      end
      if (DEF_DLY < 0 || DEF_DLY >= (1 << DLY_W)) begin : g_bad_def_dly
         $error("DEF_DLY does not fit DLY_W");
      end
   endgenerate

   logic [THR_W-1:0] thr;
   logic [DLY_W-1:0] dly;
   irq_vec_t         en_v;
   irq_vec_t         flag_v;
   irq_vec_t         set_v;
   logic             thr_chg;
   logic             reach;
   logic             pending;
   logic             expire;

   assign set_v.cmp = reach;
   assign set_v.dly = expire;
   assign set_v.err = dma_err_i;

   irqc_regs #(
      .THR_W   (THR_W),
      .DLY_W   (DLY_W),
      .DEF_THR (DEF_THR),
      .DEF_DLY (DEF_DLY)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we_i),
      .sel     (reg_sel_i),
      .wdata   (reg_wdata_i),
      .set_v   (set_v),
      .rdata   (reg_rdata_o),
      .thr     (thr),
      .dly     (dly),
      .en_v    (en_v),
      .flag_v  (flag_v),
      .thr_chg (thr_chg)
   );

   irqc_pkt_counter #(
      .THR_W (THR_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (pkt_done_i),
      .restart (thr_chg),
      .flush   (expire),
      .thr     (thr),
      .reach   (reach),
      .pending (pending)
   );

   irqc_delay_timer #(
      .DLY_W    (DLY_W),
      .PRESCALE (PRESCALE)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (pending),
      .kick    (pkt_done_i | thr_chg),
      .dly     (dly),
      .expire  (expire)
   );

   assign irq_o = |(flag_v & en_v);

   a_r2_reach_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      reach |=> flag_v.cmp && !pending);

   a_r5_expire_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag_v.dly && !pending);

   a_r6_zero_delay_silent : assert property (@(posedge clk) disable iff (!rst_n)
      (dly == '0 && !flag_v.dly && !(reg_we_i && reg_sel_i == SEL_CTRL)) |=> !flag_v.dly);

   a_r7_error_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      dma_err_i |=> flag_v.err);

   a_r9_irq_needs_enabled_flag : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $countones(flag_v & en_v) > 0);

endmodule

// File: tb/irq_coalesce_ctrl_tb.sv
`timescale 1ns/1ps
module irq_coalesce_ctrl_tb;

   localparam int PS = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        done = 1'b0;
   logic        err = 1'b0;
   logic        we = 1'b0;
   logic        sel = 1'b0;
   logic [31:0] wd = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;

   // reference model state
   logic [7:0] m_thr, m_dly;
   logic [2:0] m_en, m_flags;
   int         m_cnt, m_idle;

   always #2.5 clk = ~clk;

   irq_coalesce_ctrl #(.PRESCALE(PS)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_done_i  (done),
      .dma_err_i   (err),
      .reg_we_i    (we),
      .reg_sel_i   (sel),
      .reg_wdata_i (wd),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   function automatic logic [31:0] m_read(input logic a);
      if (a) return {17'b0, m_flags, 12'b0};
      return {m_dly, m_thr, 1'b0, m_en, 12'b0};
   endfunction

   function automatic logic m_irq();
      return |(m_flags & m_en);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_update(input logic d, input logic e, input logic w,
                               input logic a, input logic [31:0] data);
      logic       tchg, reach, expd;
      int         teff;
      logic [2:0] clr, setv;
      tchg = w && !a && (data[23:16] != m_thr);
      teff = (m_thr == 0) ? 1 : int'(m_thr);
      reach = d && !tchg && (m_cnt + 1 >= teff);
      expd = (m_cnt != 0) && !d && !tchg && (m_dly != 0) &&
             (m_idle == int'(m_dly) * PS - 1);
      setv = {e, expd, reach};
      clr = (w && a) ? data[14:12] : 3'b000;
      m_flags = (m_flags & ~clr) | setv;
      if (tchg || d || m_cnt == 0) m_idle = 0;
      else m_idle++;
      if (tchg) m_cnt = 0;
      else if (d) m_cnt = reach ? 0 : m_cnt + 1;
      else if (expd) m_cnt = 0;
      if (w && !a) begin
         m_thr = data[23:16];
         m_dly = data[31:24];
         m_en  = data[14:12];
      end
   endtask

   task automatic step(input logic d, input logic e, input logic w,
                       input logic a, input logic [31:0] data);
      done = d; err = e; we = w; sel = a; wd = data;
      @(posedge clk);
      model_update(d, e, w, a, data);
      @(negedge clk);
      check("R9 irq level", {31'b0, irq}, {31'b0, m_irq()});
      check("R2 register read", rdata, m_read(a));
      done = 1'b0; err = 1'b0; we = 1'b0;
   endtask

   task automatic pkt();                       step(1, 0, 0, 1, 0); endtask
   task automatic idle(input int n);           repeat (n) step(0, 0, 0, 1, 0); endtask
   task automatic wctrl(input logic [31:0] v); step(0, 0, 1, 0, v); endtask
   task automatic wstat(input logic [31:0] v); step(0, 0, 1, 1, v); endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_thr = 8'd24; m_dly = 8'd254; m_en = '0; m_flags = '0; m_cnt = 0; m_idle = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      sel = 1'b0; #1;
      check("R1 control reset", rdata, 32'hFE18_0000);
      sel = 1'b1; #1;
      check("R1 status reset", rdata, 32'h0);
      check("R1 irq reset", {31'b0, irq}, 32'h0);
      @(negedge clk);

      // R2: threshold 4, timer off, all enables
      wctrl(32'h0004_7000);
      repeat (3) pkt();
      check("R2 below threshold", rdata, 32'h0);
      pkt();
      check("R2 threshold reached", rdata, 32'h0000_1000);
      check("R9 irq on completion", {31'b0, irq}, 32'h1);
      wstat(32'h0000_2000);
      check("R8 other bit keeps flag", rdata, 32'h0000_1000);
      wstat(32'h0000_1000);
      check("R8 w1c clears", rdata, 32'h0);

      // R4: same threshold keeps count, changed one restarts it
      repeat (2) pkt();
      wctrl(32'h0004_7000);
      sel = 1'b1;
      repeat (2) pkt();
      check("R4 unchanged threshold keeps count", rdata, 32'h0000_1000);
      wstat(32'h0000_1000);
      repeat (2) pkt();
      wctrl(32'h0005_7000);
      repeat (4) pkt();
      check("R4 changed threshold restarts count", rdata, 32'h0);
      pkt();
      check("R4 fifth completion", rdata, 32'h0000_1000);
      wstat(32'h0000_1000);

      // R3: threshold 0 acts as 1
      wctrl(32'h0000_7000);
      pkt();
      check("R3 zero threshold first", rdata, 32'h0000_1000);
      wstat(32'h0000_1000);
      pkt();
      check("R3 zero threshold second", rdata, 32'h0000_1000);
      wstat(32'h0000_1000);

      // R5: delay 5 ticks of 3 cycles = 15 cycles, threshold 10
      wctrl(32'h050A_7000);
      pkt();
      idle(14);
      check("R5 before expiry", rdata, 32'h0);
      idle(1);
      check("R5 at expiry", rdata, 32'h0000_2000);
      repeat (9) pkt();
      check("R5 count flushed on expiry", rdata, 32'h0000_2000);
      wstat(32'h0000_2000);
      pkt();
      check("R5 tenth completion", rdata, 32'h0000_1000);
      wstat(32'h0000_1000);
      pkt();
      idle(10);
      pkt();
      idle(14);
      check("R5 completion restarts wait", rdata, 32'h0);
      idle(1);
      check("R5 expiry after restart", rdata, 32'h0000_2000);
      wstat(32'h0000_2000);

      // R6: delay 0 disables the timer
      wctrl(32'h000A_7000);
      pkt();
      idle(100);
      check("R6 no delay flag", rdata, 32'h0);

      // R7 and same-cycle set/clear
      step(0, 1, 0, 1, 0);
      check("R7 error flag", rdata, 32'h0000_4000);
      step(0, 1, 1, 1, 32'h0000_4000);
      check("R8 set wins over clear", rdata, 32'h0000_4000);
      wstat(32'h0);
      check("R8 zero write keeps", rdata, 32'h0000_4000);

      // R9: masking keeps status
      wctrl(32'h000A_0000);
      check("R9 masked irq low", {31'b0, irq}, 32'h0);
      idle(1);
      check("R9 status kept while masked", rdata, 32'h0000_4000);
      wctrl(32'h000A_4000);
      check("R9 re-enabled irq high", {31'b0, irq}, 32'h1);
      wstat(32'h0000_4000);

      // random phase: delay 3, small thresholds
      wctrl(32'h0301_7000);
      for (int i = 0; i < 5000; i++) begin
         logic       d, e, a;
         logic [7:0] t;
         int         k;
         d = ($urandom % 100) < 30;
         e = ($urandom % 50) == 0;
         k = $urandom % 40;
         case ($urandom % 5)
            0: t = 8'd0; 1: t = 8'd1; 2: t = 8'd2; 3: t = 8'd3; default: t = 8'd7;
         endcase
         if (k == 0)
            step(d, e, 1, 0, {8'd3, t, 1'b0, 3'($urandom % 8), 12'b0});
         else if (k < 3)
            step(d, e, 1, 1, {17'b0, 3'($urandom % 8), 12'b0});
         else begin
            a = $urandom % 2;
            step(d, e, 0, a, 0);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule